// File: doc/BRIEF.md
# Time-Multiplexed Multi-Plane Gamma Lookup

This block applies a per-plane gamma curve to a stream of samples from up to three color planes or channels. All planes share one data input and one data output, and only one sample is handled per clock. Each sample carries a plane number. That number picks the lookup table used for the sample and comes back out in the cycle the result is presented. Plane numbers may come in any order, so channels at different rates can share the block.

Each table is indexed by the sample and returns a corrected value of the same width. A table can be rewritten at run time. With the write strobe high, the data input is the table index, the value input is the new entry, and the plane number selects the table. A per-sample enable chooses between a corrected result and the raw input. A plane narrower than the port is carried left-aligned, with zeros in its unused low bits. Plane 0 is the widest plane and sets the port width.

The block has a clock enable, a synchronous clear and an asynchronous active-low reset. None of these ever changes the table contents. After any reset or clear, the tables hold the values they had before.

Top module: `gmux_gamma_top`

## Requirements
- R1: When `rst_n` is low, or `sync_clr` is high at a clock edge, every pipeline stage is emptied and `out_vld` goes low. `sync_clr` takes effect even while `clk_en` is low. Table contents survive both.
- R2: A sample presented with `in_vld` high and `tbl_we` low at a clock edge where `clk_en` is high appears on the outputs LATENCY register stages later, with `out_vld` high. LATENCY is 4 to 6 and defaults to 6. `out_vld` is low for every slot that was not such a sample.
- R3: Plane p has width Wp: DATA_W for plane 0, PLANE1_W for plane 1 and PLANE2_W for plane 2. The index used is the top Wp bits of `in_data`. The Wp-bit entry is returned in the top Wp bits of `out_data`, with zeros below.
- R4: At power-up, plane 0 at width 4 holds the curve 0,4,6,7,8,9,10,11,11,12,12,13,14,14,15,15 for indices 0 to 15. Every other table starts as identity, so entry i equals i.
- R5: A slot with `tbl_we` high and `clk_en` high writes the top Wp bits of `tbl_val` into the table of plane `in_plane`, at the index taken from `in_data`. Later samples read the new entry. A full reload takes one slot per entry.
- R6: A write slot performs no correction. Its output slot has `out_vld` low, whatever `in_vld` was.
- R7: With `in_corr_en` low, `out_data` equals the raw `in_data` of that sample. `out_corr` carries that sample's `in_corr_en`, delayed by the same latency.
- R8: `out_plane` equals the `in_plane` of the sample currently presented on `out_data`.
- R9: Samples of different planes may arrive in any order, with gaps. Each one is corrected by its own plane's table.
- R10: While `clk_en` is low and `sync_clr` is low, all outputs hold and all other inputs, including writes, are ignored.
- R11: A plane number of NUM_PLANES or more returns zero as its corrected value. Writes to such a plane change no table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_clr | input | 1 | Synchronous pipeline clear |
| clk_en | input | 1 | Clock enable; low freezes the block |
| in_vld | input | 1 | Sample present on `in_data` |
| in_plane | input | 2 | Plane number of the sample or write |
| in_data | input | DATA_W | Sample, left-aligned; table index during writes |
| in_corr_en | input | 1 | 1 = correct the sample, 0 = pass it raw |
| tbl_we | input | 1 | Table write strobe |
| tbl_val | input | DATA_W | Table entry to write, left-aligned |
| out_vld | output | 1 | Result present on `out_data` |
| out_plane | output | 2 | Plane number of the result |
| out_data | output | DATA_W | Corrected or raw result, left-aligned |
| out_corr | output | 1 | Result was corrected |

## Verification
Each table is read across its full index range twice: once from power-up, where an index or curve error shows up as wrong entries, and again after a full reload. In the reload pass, a write landing in the wrong table or at the wrong index leaves stale values behind. A 3-bit plane exercises left alignment, where a missing shift would return values scaled by two. Random order of planes, together with random gaps in `in_vld` and `clk_en`, would expose a plane tag that slips against its data, or a pipeline that moves while frozen. Clear and reset are applied mid-stream, including a clear during a frozen cycle. These cases catch samples that leak out after the clear and tables that were wiped with the pipeline. Samples tagged with an unmapped plane must return zero and must leave every real table untouched.

// File: rtl/gmux_pkg.sv
package gmux_pkg;

    // Plane numbers are carried on a fixed two-bit tag.
    localparam int SEL_W      = 2;
    localparam int TAG_SLOTS  = 1 << SEL_W;

    typedef enum logic {
        SLOT_READ  = 1'b0,
        SLOT_WRITE = 1'b1
    } slot_kind_e;

    // Width of a plane, given the widths of all three.
    function automatic int plane_width(int p, int w0, int w1, int w2);
        case (p)
            0:       return w0;
            1:       return w1;
            default: return w2;
        endcase
    endfunction

    // Power-up entry of a table: plane 0 at width 4 gets a fixed curve,
    // every other table starts as identity.
    function automatic logic [11:0] init_entry(int p, int w, int idx);
        logic [63:0] curve;
        curve = 64'hFFEE_DCCB_BA98_7640;
        if (p == 0 && w == 4)
            return {8'd0, curve[idx*4 +: 4]};
        return 12'(idx);
    endfunction

endpackage

// File: rtl/gmux_delay.sv
module gmux_delay #(
    parameter type T     = logic,
    parameter int  DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_clr,
    input  logic clk_en,
    input  T     d,
    output T     q
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        T nxt;
        T r_q;
        if (i == 0) begin : g_head
            assign nxt = d;
        end else begin : g_body
            assign nxt = g_stage[i-1].r_q;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                r_q <= '0;
            else if (sync_clr)
                r_q <= '0;
            else if (clk_en)
                r_q <= nxt;
        end
    end

    assign q = g_stage[DEPTH-1].r_q;

endmodule

// File: rtl/gmux_lut_bank.sv
module gmux_lut_bank
    import gmux_pkg::*;
#(
    parameter int DATA_W     = 4,
    parameter int NUM_PLANES = 3,
    parameter int PLANE1_W   = 4,
    parameter int PLANE2_W   = 3
) (
    input  logic              clk,
    input  logic              clk_en,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_plane,
    input  logic [DATA_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_val,
    input  logic [SEL_W-1:0]  rd_plane,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] rd_al [TAG_SLOTS];

    for (genvar p = 0; p < TAG_SLOTS; p++) begin : g_plane
        if (p < NUM_PLANES) begin : g_tbl
            localparam int W     = plane_width(p, DATA_W, PLANE1_W, PLANE2_W);
            localparam int DEPTH = 1 << W;
            localparam int PAD   = DATA_W - W;

            logic [W-1:0] mem [DEPTH];
            logic [W-1:0] rd_q;
            logic [W-1:0] idx;
            logic [W-1:0] val;

            assign idx = addr[DATA_W-1 -: W];
            assign val = wr_val[DATA_W-1 -: W];

            initial begin
                for (int i = 0; i < DEPTH; i++)
                    mem[i] = W'(init_entry(p, W, i));
            end

            always_ff @(posedge clk) begin
                if (wr_en && wr_plane == SEL_W'(p))
                    mem[idx] <= val;
                if (clk_en)
                    rd_q <= mem[idx];
            end

            if (PAD > 0) begin : g_pad
                assign rd_al[p] = {rd_q, {PAD{1'b0}}};
            end else begin : g_full
                assign rd_al[p] = rd_q;
            end
        end else begin : g_none
            assign rd_al[p] = '0;
        end
    end

    assign rd_data = rd_al[rd_plane];

endmodule

// File: rtl/gmux_gamma_top.sv
module gmux_gamma_top
    import gmux_pkg::*;
#(
    parameter int DATA_W     = 4,
    parameter int NUM_PLANES = 3,
    parameter int PLANE1_W   = 4,
    parameter int PLANE2_W   = 3,
    parameter int LATENCY    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_clr,
    input  logic              clk_en,
    input  logic              in_vld,
    input  logic [SEL_W-1:0]  in_plane,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_corr_en,
    input  logic              tbl_we,
    input  logic [DATA_W-1:0] tbl_val,
    output logic              out_vld,
    output logic [SEL_W-1:0]  out_plane,
    output logic [DATA_W-1:0] out_data,
    output logic              out_corr
);

    // Input stage, lookup stage, then the rest of the latency as a tag delay.
    localparam int CHAIN = LATENCY - 2;

    typedef struct packed {
        logic              vld;
        slot_kind_e        kind;
        logic              corr;
        logic [SEL_W-1:0]  plane;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] val;
    } in_slot_t;

    typedef struct packed {
        logic              vld;
        logic              corr;
        logic [SEL_W-1:0]  plane;
        logic [DATA_W-1:0] data;
    } out_slot_t;

    in_slot_t          s1_d, s1_q;
    out_slot_t         tag2_q, res, out_q;
    logic [DATA_W-1:0] lut_rd;
    logic              wr_go;

    always_comb begin
        s1_d.vld   = in_vld;
        s1_d.kind  = tbl_we ? SLOT_WRITE : SLOT_READ;
        s1_d.corr  = in_corr_en;
        s1_d.plane = in_plane;
        s1_d.data  = in_data;
        s1_d.val   = tbl_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s1_q <= '0;
        else if (sync_clr)
            s1_q <= '0;
        else if (clk_en)
            s1_q <= s1_d;
    end

    // Writes are taken from the input stage; a cleared slot never writes.
    assign wr_go = clk_en && !sync_clr && (s1_q.kind == SLOT_WRITE);

    gmux_lut_bank #(
        .DATA_W     (DATA_W),
        .NUM_PLANES (NUM_PLANES),
        .PLANE1_W   (PLANE1_W),
        .PLANE2_W   (PLANE2_W)
    ) u_bank (
        .clk      (clk),
        .clk_en   (clk_en),
        .wr_en    (wr_go),
        .wr_plane (s1_q.plane),
        .addr     (s1_q.data),
        .wr_val   (s1_q.val),
        .rd_plane (tag2_q.plane),
        .rd_data  (lut_rd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag2_q <= '0;
        end else if (sync_clr) begin
            tag2_q <= '0;
        end else if (clk_en) begin
            tag2_q.vld   <= s1_q.vld && (s1_q.kind == SLOT_READ);
            tag2_q.corr  <= s1_q.corr;
            tag2_q.plane <= s1_q.plane;
            tag2_q.data  <= s1_q.data;
        end
    end

    always_comb begin
        res      = tag2_q;
        res.data = tag2_q.corr ? lut_rd : tag2_q.data;
    end

    gmux_delay #(
        .T     (out_slot_t),
        .DEPTH (CHAIN)
    ) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_clr (sync_clr),
        .clk_en   (clk_en),
        .d        (res),
        .q        (out_q)
    );

    assign out_vld   = out_q.vld;
    assign out_plane = out_q.plane;
    assign out_data  = out_q.data;
    assign out_corr  = out_q.corr;

endmodule

// File: rtl/gmux_gamma_chk.sv
module gmux_gamma_chk
    import gmux_pkg::*;
#(
    parameter int DATA_W  = 4,
    parameter int LATENCY = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sync_clr,
    input logic              clk_en,
    input logic              in_vld,
    input logic [SEL_W-1:0]  in_plane,
    input logic [DATA_W-1:0] in_data,
    input logic              in_corr_en,
    input logic              tbl_we,
    input logic              out_vld,
    input logic [SEL_W-1:0]  out_plane,
    input logic [DATA_W-1:0] out_data,
    input logic              out_corr
);

    typedef struct packed {
        logic              vld;
        logic              corr;
        logic [SEL_W-1:0]  plane;
        logic [DATA_W-1:0] raw;
    } shadow_t;

    // Independent record of what each output slot must carry.
    shadow_t sh_q [LATENCY];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LATENCY; i++) sh_q[i] <= '0;
        end else if (sync_clr) begin
            for (int i = 0; i < LATENCY; i++) sh_q[i] <= '0;
        end else if (clk_en) begin
            sh_q[0] <= '{vld: in_vld && !tbl_we, corr: in_corr_en,
                         plane: in_plane, raw: in_data};
            for (int i = 1; i < LATENCY; i++) sh_q[i] <= sh_q[i-1];
        end
    end

    AST_VLD_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld == sh_q[LATENCY-1].vld); // R2

    AST_PLANE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> out_plane == sh_q[LATENCY-1].plane); // R8

    AST_CORR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> out_corr == sh_q[LATENCY-1].corr); // R7

    AST_BYPASS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_corr) |-> out_data == sh_q[LATENCY-1].raw); // R7

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        sync_clr |=> !out_vld); // R1

    AST_CE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && !sync_clr) |=> ($stable(out_vld) && $stable(out_data)
                                    && $stable(out_plane) && $stable(out_corr))); // R10

endmodule

bind gmux_gamma_top gmux_gamma_chk #(
    .DATA_W  (DATA_W),
    .LATENCY (LATENCY)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_clr   (sync_clr),
    .clk_en     (clk_en),
    .in_vld     (in_vld),
    .in_plane   (in_plane),
    .in_data    (in_data),
    .in_corr_en (in_corr_en),
    .tbl_we     (tbl_we),
    .out_vld    (out_vld),
    .out_plane  (out_plane),
    .out_data   (out_data),
    .out_corr   (out_corr)
);

// File: tb/tb_gmux_gamma_top.sv
module tb_gmux_gamma_top;

    localparam int DW  = 4;
    localparam int NP  = 3;
    localparam int W1  = 4;
    localparam int W2  = 3;
    localparam int LAT = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sync_clr;
    logic          clk_en;
    logic          in_vld;
    logic [1:0]    in_plane;
    logic [DW-1:0] in_data;
    logic          in_corr_en;
    logic          tbl_we;
    logic [DW-1:0] tbl_val;
    logic          out_vld;
    logic [1:0]    out_plane;
    logic [DW-1:0] out_data;
    logic          out_corr;

    always #10 clk = ~clk;   // 50 MHz

    gmux_gamma_top #(
        .DATA_W(DW), .NUM_PLANES(NP), .PLANE1_W(W1), .PLANE2_W(W2), .LATENCY(LAT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .clk_en(clk_en),
        .in_vld(in_vld), .in_plane(in_plane), .in_data(in_data),
        .in_corr_en(in_corr_en), .tbl_we(tbl_we), .tbl_val(tbl_val),
        .out_vld(out_vld), .out_plane(out_plane), .out_data(out_data),
        .out_corr(out_corr)
    );

    typedef struct {
        bit vld;
        bit corr;
        int plane;
        int data;
    } exp_t;

    int   n_cmp = 0;
    int   n_bad = 0;
    int   tbl [4][16];
    exp_t pipe [LAT];

    function automatic int pwidth(int p);
        return (p == 0) ? DW : (p == 1) ? W1 : W2;
    endfunction

    function automatic int shift_of(int p);
        return DW - pwidth(p);
    endfunction

    function automatic int expect_data(int p, int din, bit corr);
        if (!corr)   return din;
        if (p >= NP) return 0;
        return tbl[p][din >> shift_of(p)] << shift_of(p);
    endfunction

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One slot: drive at the falling edge, update the model, then compare
    // the outputs after the next rising edge.
    task automatic step(string tag, bit vld, bit corr, int p, int din,
                        bit we, int val, bit ce, bit clr);
        in_vld     = vld;
        in_corr_en = corr;
        in_plane   = 2'(p);
        in_data    = DW'(din);
        tbl_we     = we;
        tbl_val    = DW'(val);
        clk_en     = ce;
        sync_clr   = clr;
        if (clr) begin
            for (int i = 0; i < LAT; i++) pipe[i].vld = 1'b0;
        end else if (ce) begin
            for (int i = LAT-1; i > 0; i--) pipe[i] = pipe[i-1];
            pipe[0].vld   = vld && !we;
            pipe[0].corr  = corr;
            pipe[0].plane = p;
            pipe[0].data  = expect_data(p, din, corr);
            if (we && p < NP)
                tbl[p][din >> shift_of(p)] = val >> shift_of(p);
        end
        @(posedge clk);
        @(negedge clk);
        check(clr ? "R1 clear" : (!ce ? "R10 hold valid" : {tag, " R2 valid"}),
              int'(out_vld), int'(pipe[LAT-1].vld));
        if (pipe[LAT-1].vld) begin
            check({tag, " data"}, int'(out_data), pipe[LAT-1].data);
            check("R8 plane", int'(out_plane), pipe[LAT-1].plane);
            check("R7 corrected flag", int'(out_corr), int'(pipe[LAT-1].corr));
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step("idle", 0, 0, 0, 0, 0, 0, 1, 0);
    endtask

    task automatic sweep(string tag, int p);
        for (int a = 0; a < (1 << pwidth(p)); a++)
            step(tag, 1, 1, p, a << shift_of(p), 0, 0, 1, 0);
    endtask

    initial begin
        #(20 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int c0 [16] = '{0, 4, 6, 7, 8, 9, 10, 11, 11, 12, 12, 13, 14, 14, 15, 15};
        void'($urandom(32'd20240611));
        for (int p = 0; p < 4; p++)
            for (int a = 0; a < 16; a++)
                tbl[p][a] = (p == 0) ? c0[a] : a;
        for (int i = 0; i < LAT; i++) pipe[i] = '{0, 0, 0, 0};

        rst_n = 1'b0; sync_clr = 1'b0; clk_en = 1'b1; in_vld = 1'b0;
        in_plane = '0; in_data = '0; in_corr_en = 1'b0; tbl_we = 1'b0; tbl_val = '0;
        repeat (3) @(negedge clk);
        check("R1 reset out_vld", int'(out_vld), 0);
        rst_n = 1'b1;
        idle(2);

        // R4: power-up contents; R3: plane 2 is 3 bits wide, left-aligned.
        sweep("R4 initial plane0", 0);
        sweep("R4 initial plane1", 1);
        sweep("R4 R3 initial plane2", 2);
        idle(LAT);

        // R5 reload, with in_vld high during writes to exercise R6.
        for (int a = 0; a < 16; a++) step("R6 write slot", 1, 1, 1, a, 1, 15 - a, 1, 0);
        sweep("R5 reloaded plane1", 1);
        for (int a = 0; a < 8; a++)
            step("R6 write slot", 1, 1, 2, a << 1, 1, ((a * 3) & 7) << 1, 1, 0);
        sweep("R5 R3 reloaded plane2", 2);
        idle(LAT);

        // R7: bypass returns raw input.
        for (int i = 0; i < 20; i++) begin
            int p = i % 3;
            int d = ((int'($urandom) & 15) >> shift_of(p)) << shift_of(p);
            step("R7 bypass", 1, 0, p, d, 0, 0, 1, 0);
        end

        // R9/R3/R10: random plane order, gaps, writes, frozen cycles.
        for (int i = 0; i < 400; i++) begin
            int  p    = int'($urandom % 3);
            int  d    = ((int'($urandom) & 15) >> shift_of(p)) << shift_of(p);
            int  v    = ((int'($urandom) & 15) >> shift_of(p)) << shift_of(p);
            bit  vld  = ($urandom % 4) != 0;
            bit  corr = ($urandom % 5) != 0;
            bit  we   = ($urandom % 20) == 0;
            bit  ce   = ($urandom % 7) != 0;
            step("R9 R3 mixed", vld, corr, p, d, we, v, ce, 0);
        end
        idle(2);

        // R1: clear mid-stream, including a clear during a frozen cycle.
        for (int i = 0; i < 4; i++) step("R1 pre-clear", 1, 1, i % 3, 8, 0, 0, 1, 0);
        step("R1 clear", 1, 1, 0, 4, 0, 0, 1, 1);
        for (int i = 0; i < 3; i++) step("R1 after clear", 1, 1, 1, 2 * i, 0, 0, 1, 0);
        step("R1 clear frozen", 1, 1, 0, 4, 0, 0, 0, 1);
        idle(LAT);

        // R11: unmapped plane returns zero and its writes touch nothing.
        step("R11 unmapped read", 1, 1, 3, 5, 0, 0, 1, 0);
        step("R11 unmapped write", 0, 0, 3, 5, 1, 9, 1, 0);
        step("R11 unmapped read", 1, 1, 3, 5, 0, 0, 1, 0);
        idle(1);
        sweep("R11 plane0 intact", 0);
        sweep("R11 plane1 intact", 1);
        idle(LAT);

        // R1: asynchronous reset mid-stream keeps the tables.
        for (int i = 0; i < 4; i++) step("R1 pre-reset", 1, 1, 2, 4, 0, 0, 1, 0);
        rst_n = 1'b0;
        #1;
        for (int i = 0; i < LAT; i++) pipe[i].vld = 1'b0;
        check("R1 async reset out_vld", int'(out_vld), 0);
        @(posedge clk);
        @(negedge clk);
        check("R1 reset held out_vld", int'(out_vld), 0);
        rst_n = 1'b1;
        sweep("R1 tables kept plane1", 1);
        sweep("R1 tables kept plane2", 2);
        idle(LAT);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule